// File: doc/BRIEF.md
# Reciprocal Multiplier Constant Generator

This block turns an unsigned 32-bit divisor into the three constants that a multiply-high unit needs to divide by that divisor: a post-shift amount, a 32-bit multiplier and a round-down correction flag. Divide-by-constant datapaths use these constants in place of a real divider. The host sets the divisor and pulses `start_i`. The block then works the result out one bit per cycle and pulses `done_o` with the constants on its outputs. The outputs keep that value until the next result is ready.

The post-shift is the index of the divisor's highest set bit. A priority encoder finds it in the cycle that accepts the start. A serial restoring divider then divides the fixed power of two 2^(shift+32) by the divisor. It runs 64 iterations and yields the low quotient bits and the remainder. In the next cycle the quotient is rounded up to a ceiling. The round-down variant is chosen when the remainder does not exceed 2^shift. The multiplier's top bit is always reported as zero, because the consumer supplies that bit itself. A separate flag reports when the divisor is an exact power of two, so the caller can use a plain shift instead. The constants are produced in that case as well.

Top module: `magic_div_gen`

## Requirements
- R1: After reset, `done_o`, `busy_o`, `round_down_o`, `pow2_o`, `shift_o` and `magic_o` are all zero.
- R2: `shift_o` equals floor(log2 d) for the divisor d that was accepted.
- R3: Let N = 2^(shift+32), q = floor(N/d), r = N mod d and c = q + (r != 0). The full multiplier M (c or c-1, see R4 and R5) lies in [2^31, 2^32). `magic_o` is M with bit 31 forced to 0.
- R4: When r ≤ 2^shift, `round_down_o` = 1 and M = c − 1.
- R5: When r > 2^shift, `round_down_o` = 0 and M = c.
- R6: `pow2_o` = 1 exactly when d has a single set bit. The other outputs follow R2–R5 in that case too.
- R7: `done_o` is a one-cycle pulse that rises on the 65th rising edge after the edge that accepted `start_i`. `busy_o` is high from the accepting edge until that pulse, and `done_o` is never high while `busy_o` is.
- R8: A `start_i` seen while `busy_o` is high is ignored. The running job keeps its timing and its results, and it produces only one `done_o` pulse.
- R9: Result outputs change only on the edge that raises `done_o` and hold otherwise. A start given in the `done_o` cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse; accepted when not busy |
| divisor_i | input | 32 | Divisor d (d ≥ 1), sampled with an accepted start |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle result strobe |
| shift_o | output | 5 | floor(log2 d) |
| magic_o | output | 32 | Multiplier with its top bit cleared |
| round_down_o | output | 1 | Round-down correction required |
| pow2_o | output | 1 | d is a power of two |

## Verification
Two events can fall in the same cycle: the completion strobe of one job and the acceptance of the next start. The bench raises `start_i` with a new divisor during the cycle in which `done_o` is high. It then checks three things. The first job's constants must still be on the outputs one cycle later. `busy_o` must already be high. The second job must complete exactly 65 edges after its accepting edge, with its own constants. A start raised in the middle of a job is also applied, to show that it neither restarts the divider nor adds a second strobe.

// File: rtl/magic_div_pkg.sv
package magic_div_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_FIN  = 2'd2
  } md_phase_e;
endpackage

// File: rtl/md_msb_enc.sv
module md_msb_enc #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  val_i,
  output logic [SW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (val_i[i]) idx_o = SW'(i);
    end
  end
endmodule

// File: rtl/md_serial_div.sv
// Restoring divider of 2^exp by d; keeps only the low QW quotient bits.
module md_serial_div #(
  parameter int W  = 32,
  parameter int DW = 2 * W,
  parameter int EW = $clog2(DW),
  parameter int QW = W - 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [W-1:0]  d_i,
  input  logic [EW-1:0] exp_i,
  output logic          last_o,
  output logic [QW-1:0] quo_o,
  output logic [W-1:0]  rem_o
);
  logic [W-1:0]  d_q, rem_q;
  logic [QW-1:0] quo_q;
  logic [EW-1:0] exp_q, cnt_q;
  logic [EW-1:0] bit_idx;
  logic [W:0]    rem_sh;
  logic          ge;

  assign bit_idx = EW'(DW - 1) - cnt_q;
  assign rem_sh  = {rem_q, bit_idx == exp_q};
  assign ge      = rem_sh >= {1'b0, d_q};
  assign last_o  = step_i && (cnt_q == EW'(DW - 1));
  assign quo_o   = quo_q;
  assign rem_o   = rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_q   <= '0;
      rem_q <= '0;
      quo_q <= '0;
      exp_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      d_q   <= d_i;
      exp_q <= exp_i;
      rem_q <= '0;
      quo_q <= '0;
      cnt_q <= '0;
    end else if (step_i) begin
      rem_q <= ge ? (rem_sh[W-1:0] - d_q) : rem_sh[W-1:0];
      quo_q <= {quo_q[QW-2:0], ge};
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/md_round_sel.sv
// Ceiling, round-down choice and top-bit drop; arithmetic is modulo 2^(W-1).
module md_round_sel #(
  parameter int W  = 32,
  parameter int SW = $clog2(W),
  parameter int QW = W - 1
) (
  input  logic [QW-1:0] quo_i,
  input  logic [W-1:0]  rem_i,
  input  logic [SW-1:0] shift_i,
  output logic [W-1:0]  magic_o,
  output logic          round_down_o
);
  logic [W:0]    thresh;
  logic [QW-1:0] ceil_lo;

  assign thresh       = (W+1)'(1) << shift_i;
  assign round_down_o = {1'b0, rem_i} <= thresh;
  assign ceil_lo      = quo_i + QW'(rem_i != '0);
  assign magic_o      = {1'b0, ceil_lo - QW'(round_down_o)};
endmodule

// File: rtl/magic_div_gen.sv
module magic_div_gen #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [W-1:0]  divisor_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [SW-1:0] shift_o,
  output logic [W-1:0]  magic_o,
  output logic          round_down_o,
  output logic          pow2_o
);
  import magic_div_pkg::*;

  localparam int DW = 2 * W;
  localparam int EW = $clog2(DW);
  localparam int QW = W - 1;

  md_phase_e     phase_q;
  logic          accept, last;
  logic [SW-1:0] msb, shift_q;
  logic          pow2_q;
  logic [QW-1:0] quo;
  logic [W-1:0]  rem, magic_d;
  logic          rd_d;

  assign accept = start_i && (phase_q == PH_IDLE);
  assign busy_o = phase_q != PH_IDLE;

  md_msb_enc #(.W(W), .SW(SW)) u_enc (
    .val_i (divisor_i),
    .idx_o (msb)
  );

  md_serial_div #(.W(W), .DW(DW), .EW(EW), .QW(QW)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .step_i (phase_q == PH_RUN),
    .d_i    (divisor_i),
    .exp_i  (EW'(msb) + EW'(W)),
    .last_o (last),
    .quo_o  (quo),
    .rem_o  (rem)
  );

  md_round_sel #(.W(W), .SW(SW), .QW(QW)) u_rnd (
    .quo_i        (quo),
    .rem_i        (rem),
    .shift_i      (shift_q),
    .magic_o      (magic_d),
    .round_down_o (rd_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q      <= PH_IDLE;
      shift_q      <= '0;
      pow2_q       <= 1'b0;
      done_o       <= 1'b0;
      shift_o      <= '0;
      magic_o      <= '0;
      round_down_o <= 1'b0;
      pow2_o       <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (accept) begin
          phase_q <= PH_RUN;
          shift_q <= msb;
          pow2_q  <= (divisor_i != '0) && ((divisor_i & (divisor_i - 1'b1)) == '0);
        end
        PH_RUN: if (last) phase_q <= PH_FIN;
        PH_FIN: begin
          phase_q      <= PH_IDLE;
          done_o       <= 1'b1;
          shift_o      <= shift_q;
          magic_o      <= magic_d;
          round_down_o <= rd_d;
          pow2_o       <= pow2_q;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/magic_div_gen_chk.sv
module magic_div_gen_chk #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [W-1:0]  divisor_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [SW-1:0] shift_o,
  input logic [W-1:0]  magic_o,
  input logic          round_down_o,
  input logic          pow2_o
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_START_SETS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R7
  AST_NO_DONE_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o); // R7
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o)); // R7
  AST_TOP_BIT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !magic_o[W-1]); // R3
  AST_POW2_ROUNDS_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && pow2_o) |-> round_down_o); // R4
  AST_MAGIC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(magic_o) |-> done_o); // R9
  AST_SHIFT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(shift_o) |-> done_o); // R9
endmodule

bind magic_div_gen magic_div_gen_chk #(.W(W), .SW(SW)) u_chk (.*);

// File: tb/magic_div_gen_bench.sv
`timescale 1ns/1ps
module magic_div_gen_bench;
  localparam int W   = 32;
  localparam int LAT = 2 * W + 1;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] divisor_i = '0;
  logic        busy_o, done_o, round_down_o, pow2_o;
  logic [4:0]  shift_o;
  logic [31:0] magic_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk_i = ~clk_i;

  magic_div_gen u_magic_div_gen (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_for(input logic [31:0] d, input string tag);
    longint unsigned n, q, r, c, m;
    int s;
    bit rd;
    s = 0;
    for (int i = 0; i < 32; i++) if (d[i]) s = i;
    n  = 64'd1 << (s + 32);
    q  = n / d;
    r  = n % d;
    c  = q + (r != 0);
    rd = r <= (64'd1 << s);
    m  = rd ? c - 1 : c;
    chk(shift_o == 5'(s), {"R2 shift ", tag}, shift_o, s);
    chk(m >= 64'h8000_0000 && m < 64'h1_0000_0000, {"R3 range ", tag}, m, 64'h8000_0000);
    chk(magic_o == {1'b0, m[30:0]}, {"R3 magic ", tag}, magic_o, {1'b0, m[30:0]});
    if (rd) chk(round_down_o == 1'b1, {"R4 flag ", tag}, round_down_o, 1);
    else    chk(round_down_o == 1'b0, {"R5 flag ", tag}, round_down_o, 0);
    chk(pow2_o == ((d & (d - 1)) == 0), {"R6 pow2 ", tag}, pow2_o, (d & (d - 1)) == 0);
  endtask

  // drive at a negedge; returns at the negedge after the accepting edge
  task automatic launch(input logic [31:0] d);
    start_i = 1'b1;
    divisor_i = d;
    @(negedge clk_i);
    start_i = 1'b0;
    divisor_i = '0;
  endtask

  task automatic wait_done(inout int lat);
    while (!done_o && lat < 4 * LAT) begin
      @(negedge clk_i);
      lat++;
    end
  endtask

  task automatic t_reset();
    chk(!done_o && !busy_o && !round_down_o && !pow2_o && shift_o == 0 && magic_o == 0,
        "R1 reset", {done_o, busy_o, round_down_o, pow2_o, shift_o}, 0);
  endtask

  task automatic t_single(input logic [31:0] d, input string tag);
    int lat = 0;
    @(negedge clk_i);
    launch(d);
    chk(busy_o, {"R7 busy ", tag}, busy_o, 1);
    wait_done(lat);
    chk(lat == LAT, {"R7 latency ", tag}, lat, LAT);
    expect_for(d, tag);
    @(negedge clk_i);
    chk(!done_o, {"R7 pulse ", tag}, done_o, 0);
    expect_for(d, {tag, " held R9"});
  endtask

  task automatic t_start_while_busy();
    int lat = 0;
    int pulses = 0;
    @(negedge clk_i);
    launch(32'd70);
    repeat (10) begin @(negedge clk_i); lat++; end
    start_i = 1'b1; divisor_i = 32'd3;
    @(negedge clk_i); lat++;
    start_i = 1'b0; divisor_i = '0;
    wait_done(lat);
    chk(lat == LAT, "R8 latency unchanged", lat, LAT);
    expect_for(32'd70, "R8 first kept");
    repeat (2 * LAT) begin
      @(negedge clk_i);
      if (done_o) pulses++;
    end
    chk(pulses == 0, "R8 single done", pulses, 0);
    chk(!busy_o, "R8 idle after", busy_o, 0);
  endtask

  task automatic t_start_on_done();
    int lat = 0;
    @(negedge clk_i);
    launch(32'd1000);
    wait_done(lat);
    launch(32'd7);
    chk(busy_o, "R9 accepted in done cycle", busy_o, 1);
    expect_for(32'd1000, "R9 old held");
    lat = 0;
    wait_done(lat);
    chk(lat == LAT, "R9 second latency", lat, LAT);
    expect_for(32'd7, "R9 second");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_single(32'd1, "d1");
    t_single(32'd3, "d3");
    t_single(32'd5, "d5");
    t_single(32'd7, "d7");
    t_single(32'd70, "d70");
    t_single(32'd641, "d641");
    t_single(32'h0001_0000, "pow2_16");
    t_single(32'h8000_0000, "pow2_31");
    t_single(32'hFFFF_FFFF, "dmax");
    t_single(32'h8000_0001, "dtopplus1");
    t_single(32'd12345679, "d12345679");
    t_start_while_busy();
    t_start_on_done();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule